// File: doc/BRIEF.md
# Relocatable Peripheral Page Decoder

This block sits on a 16-bit external data bus driven by byte-wide load/store accesses. It lets a bank of up to 256 byte-wide peripheral registers appear on any aligned 256-byte page of the 64K space. The page is chosen by a base register that always lives at the very top address, FFFFh. Software writes the upper address byte of the desired page there with an ordinary bus write.

The block does not hold the peripheral registers. It classifies each access and then does one of three things:
- asserts a peripheral select and presents the low address byte as the register offset;
- serves the base register itself;
- answers nothing.

A read returns the base value, the peripheral's read data or zero, depending on that classification. A page-configured flag stays low after reset until the first base write. This lets system logic see that software has not yet placed the page.

Top module: `periph_page_decoder`

## Requirements
- R1: After reset the base register is 00h, so the page covers 0000h to 00FFh, and the page-configured output `page_cfg` is 0.
- R2: `per_sel` is 1 exactly when `bus_rd` or `bus_wr` is 1, `bus_addr[15:8]` equals the base register, and `bus_addr` is not FFFFh.
- R3: `per_off` always equals `bus_addr[7:0]`.
- R4: A clock edge with `bus_wr` = 1 and `bus_addr` = FFFFh loads `bus_wdata` into the base register. The new page governs `per_sel` from the next cycle on.
- R5: An access to FFFFh never asserts `per_sel`, even when the base is FFh. In that case peripheral offset FFh cannot be reached.
- R6: A read (`bus_rd` = 1) at FFFFh returns the current base register value on `bus_rdata` in the same cycle.
- R7: A read that asserts `per_sel` returns `per_rdata` on `bus_rdata` in the same cycle.
- R8: When `bus_rd` is 0, or when the read address is neither FFFFh nor inside the page, `bus_rdata` is 00h.
- R9: `page_cfg` rises on the edge of the first base write and stays 1 until reset. Writes to any other address change neither the base nor `page_cfg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 16 | External data address |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| per_rdata | input | 8 | Read data from the peripheral register bank |
| per_sel | output | 1 | Peripheral select |
| per_off | output | 8 | Register offset within the page |
| bus_rdata | output | 8 | Decoded read data back to the bus |
| page_cfg | output | 1 | Base register has been written since reset |

## Verification
Select, offset and read data are combinational from the current address, the strobes and the base register. The bench drives each access just after a falling edge and compares these outputs a quarter period later, within that same cycle. A base write counts only at the following rising edge. The bench therefore updates its own base and configured-flag model after that edge, so `page_cfg` and the new page are first expected one access later. Peripheral writes land in the bench's register model at the same edge, and a later read of that offset expects them back.

// File: rtl/ppd_pkg.sv
package ppd_pkg;

  // Classification of one bus cycle.
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,  // no strobe
    ACC_CTRL = 2'd1,  // base register address
    ACC_PAGE = 2'd2,  // inside the selected page
    ACC_MISS = 2'd3   // strobe elsewhere
  } acc_kind_e;

endpackage

// File: rtl/ppd_classify.sv
module ppd_classify
  import ppd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 8,
  localparam int PAGE_W = ADDR_W - OFF_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [PAGE_W-1:0] base,
  input  logic              strobe,
  output acc_kind_e         kind,
  output logic [OFF_W-1:0]  off
);

  function automatic logic [PAGE_W-1:0] page_field(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W];
  endfunction

  function automatic logic is_ctrl_addr(input logic [ADDR_W-1:0] a);
    return &a;
  endfunction

  always_comb begin
    if (!strobe)
      kind = ACC_NONE;
    else if (is_ctrl_addr(addr))
      kind = ACC_CTRL;
    else if (page_field(addr) == base)
      kind = ACC_PAGE;
    else
      kind = ACC_MISS;
  end

  assign off = addr[OFF_W-1:0];

endmodule

// File: rtl/ppd_base_reg.sv
module ppd_base_reg #(
  parameter int PAGE_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] wdata,
  output logic [PAGE_W-1:0] base_q,
  output logic              cfg_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cfg_q  <= 1'b0;
    end else if (load) begin
      base_q <= wdata[PAGE_W-1:0];
      cfg_q  <= 1'b1;
    end
  end

endmodule

// File: rtl/ppd_rdmux.sv
module ppd_rdmux
  import ppd_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int DATA_W = 8
) (
  input  acc_kind_e         kind,
  input  logic              rd,
  input  logic [PAGE_W-1:0] base,
  input  logic [DATA_W-1:0] per_rdata,
  output logic [DATA_W-1:0] rdata
);

  function automatic logic [DATA_W-1:0] widen_base(input logic [PAGE_W-1:0] b);
    logic [DATA_W-1:0] r;
    r = '0;
    r[PAGE_W-1:0] = b;
    return r;
  endfunction

  always_comb begin
    rdata = '0;
    if (rd) begin
      unique case (kind)
        ACC_CTRL: rdata = widen_base(base);
        ACC_PAGE: rdata = per_rdata;
        default:  rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/periph_page_decoder.sv
module periph_page_decoder
  import ppd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int OFF_W  = 8,
  localparam int PAGE_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] per_rdata,
  output logic              per_sel,
  output logic [OFF_W-1:0]  per_off,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              page_cfg
);

  // Named internal events for the checker.
  acc_kind_e         acc_kind;
  logic [PAGE_W-1:0] base_q;
  logic              base_load;
  logic              strobe;

  assign strobe = bus_rd | bus_wr;

  ppd_classify #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_cls (
    .addr   (bus_addr),
    .base   (base_q),
    .strobe (strobe),
    .kind   (acc_kind),
    .off    (per_off)
  );

  assign base_load = bus_wr && (acc_kind == ACC_CTRL);

  ppd_base_reg #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_base (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (base_load),
    .wdata  (bus_wdata),
    .base_q (base_q),
    .cfg_q  (page_cfg)
  );

  assign per_sel = (acc_kind == ACC_PAGE);

  ppd_rdmux #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_rd (
    .kind      (acc_kind),
    .rd        (bus_rd),
    .base      (base_q),
    .per_rdata (per_rdata),
    .rdata     (bus_rdata)
  );

endmodule

// File: rtl/ppd_chk.sv
module ppd_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int OFF_W  = 8,
  localparam int PAGE_W = ADDR_W - OFF_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic              per_sel,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              page_cfg,
  input logic [PAGE_W-1:0] base_q
);

  logic top_hit;
  assign top_hit = &bus_addr;

  // R4
  base_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && top_hit) |=> (base_q == $past(bus_wdata[PAGE_W-1:0])));

  // R9
  base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && top_hit) |=> $stable(base_q));

  // R9
  cfg_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    page_cfg |=> page_cfg);

  // R5
  top_no_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    top_hit |-> !per_sel);

  // R2
  sel_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_sel |-> ((bus_rd || bus_wr) && (bus_addr[ADDR_W-1:OFF_W] == base_q)));

  // R6
  top_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && top_hit) |-> (bus_rdata[PAGE_W-1:0] == base_q));

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == '0));

endmodule

bind periph_page_decoder ppd_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .per_sel   (per_sel),
  .bus_rdata (bus_rdata),
  .page_cfg  (page_cfg),
  .base_q    (base_q)
);

// File: tb/tb_periph_page_decoder.sv
module tb_periph_page_decoder;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  per_rdata;
  logic        per_sel;
  logic [7:0]  per_off;
  logic [7:0]  bus_rdata;
  logic        page_cfg;

  int n_run = 0;
  int n_fail = 0;

  logic [7:0] exp_base = 8'h00;
  logic       exp_cfg  = 1'b0;
  logic [7:0] pmem [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  periph_page_decoder dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .per_rdata(per_rdata),
    .per_sel(per_sel), .per_off(per_off), .bus_rdata(bus_rdata),
    .page_cfg(page_cfg)
  );

  // Peripheral register bank model.
  assign per_rdata = pmem[per_off];
  always @(posedge clk) if (per_sel && bus_wr) pmem[per_off] <= bus_wdata;

  function automatic logic f_sel(input logic rd, input logic wr,
                                 input logic [15:0] a, input logic [7:0] b);
    if (a == 16'hFFFF) return 1'b0;
    return (rd || wr) && (a[15:8] == b);
  endfunction

  function automatic logic [7:0] f_rdata(input logic rd, input logic wr,
                                         input logic [15:0] a, input logic [7:0] b);
    if (!rd) return 8'h00;
    if (a == 16'hFFFF) return b;
    if (f_sel(rd, wr, a, b)) return pmem[a[7:0]];
    return 8'h00;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic rd, input logic wr,
                        input logic [15:0] a, input logic [7:0] d, input string req);
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
    #(CLK_PERIOD/4);
    check({req, "/R2"}, "per_sel", {15'd0, per_sel}, {15'd0, f_sel(rd, wr, a, exp_base)});
    check({req, "/R3"}, "per_off", {8'd0, per_off}, {8'd0, a[7:0]});
    check({req, "/R8"}, "bus_rdata", {8'd0, bus_rdata}, {8'd0, f_rdata(rd, wr, a, exp_base)});
    check({req, "/R9"}, "page_cfg", {15'd0, page_cfg}, {15'd0, exp_cfg});
    @(posedge clk);
    if (wr && a == 16'hFFFF) begin
      exp_base = d;
      exp_cfg  = 1'b1;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) pmem[i] = 8'(i ^ 8'h5A);

    // R1: reset state, read of the top address during reset
    bus_rd = 1'b1; bus_addr = 16'hFFFF;
    #(CLK_PERIOD * 2 + 1);
    check("R1", "page_cfg in reset", {15'd0, page_cfg}, 16'd0);
    check("R1", "base in reset", {8'd0, bus_rdata}, 16'h0000);
    bus_rd = 1'b0;
    @(negedge clk); rst_n = 1'b1;

    // R1/R7: default page 00xx reachable before configuration
    access(1, 0, 16'h0034, 8'h00, "R1");
    access(1, 0, 16'h0134, 8'h00, "R8");
    access(0, 0, 16'h0010, 8'h00, "R8");
    // R4: program base 12h, new page next access
    access(0, 1, 16'hFFFF, 8'h12, "R4");
    access(1, 0, 16'hFFFF, 8'h00, "R6");
    access(1, 0, 16'h1200, 8'h00, "R7");
    access(0, 1, 16'h12AB, 8'hC3, "R2");
    access(1, 0, 16'h12AB, 8'h00, "R7");
    access(1, 0, 16'h0034, 8'h00, "R8");
    access(0, 1, 16'h4000, 8'h77, "R9");
    access(1, 0, 16'hFFFF, 8'h00, "R9");
    // R5: base FFh, top address never selects
    access(0, 1, 16'hFFFF, 8'hFF, "R4");
    access(1, 0, 16'hFFFF, 8'h00, "R5");
    access(0, 1, 16'hFFFF, 8'hFF, "R5");
    access(1, 0, 16'hFF00, 8'h00, "R2");
    access(1, 0, 16'hFFFE, 8'h00, "R7");
    access(0, 1, 16'hFFFE, 8'h99, "R2");
    access(1, 0, 16'hFFFE, 8'h00, "R7");

    // Random mix
    for (int k = 0; k < 3000; k++) begin
      logic [15:0] a;
      logic [2:0]  pick;
      logic        rd, wr;
      pick = 3'($urandom_range(0, 7));
      a = 16'($urandom);
      if (pick < 3)       a[15:8] = exp_base;
      else if (pick == 3) a = 16'hFFFF;
      rd = 1'($urandom);
      wr = rd ? 1'b0 : 1'($urandom);
      access(rd, wr, a, 8'($urandom), "R2");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule